// File: doc/BRIEF.md
# Serial Audio Stereo Word Deserializer

This block receives a three-wire stereo audio stream as a slave. The bit clock comes from elsewhere and clocks the whole block. Every rising edge samples the channel-select line and the data line. The data arrives MSB first. After each change of the channel-select line, a one-hot bit pointer steers each incoming bit into a fixed position of a `WORD_W`-bit capture register, starting at the top bit.

If a word is longer than the register, its tail bits are dropped. If it is shorter, the unfilled low bits stay zero. Either way the MSB keeps its place, so the sender and receiver need not agree on the word length.

When the channel-select line changes, the captured word is written whole to the left or the right output register, according to the channel that has just ended. A one-cycle strobe marks the update and carries a tag that names the channel. A parameter selects how the pointer is built: a walking one-hot register, or a small counter followed by a decoder. Both variants behave the same at the ports.

Top module: `aud_rx_deser`

## Requirements
- R1: On reset (active-low `rst_n`), both output words are zero and `word_valid` is low, and they stay so until a word is delivered.
- R2: The first data bit sampled after the sample in which the channel-select line changes goes to bit `WORD_W-1` of the captured word. Each following bit goes one position lower.
- R3: A word is committed to `left_word` when the channel-select level during that word was 0, and to `right_word` when it was 1. `word_is_right` equals that level during the strobe. The final bit of a word is sampled at the same edge as the new channel-select level, and the outputs change at the next rising edge.
- R4: When a word carries more than `WORD_W` bits, the delivered value is its first `WORD_W` bits, and the surplus bits are ignored.
- R5: When a word carries fewer than `WORD_W` bits, its bits fill the top positions and the low positions read zero.
- R6: `word_valid` is high for exactly the cycle after a committed channel change and low otherwise. The output register of the other channel keeps its value.
- R7: After reset, the word that ends at the first channel-select change is not delivered, so no strobe is raised for it.
- R8: The capture register is cleared at every channel change, so no bit of an earlier longer word appears in a later shorter one.
- R9: The one-hot pointer variant (`PTR_ONEHOT=1`) and the counter-and-decoder variant (`PTR_ONEHOT=0`) give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial bit clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_in | input | 1 | Channel select: 0 left, 1 right |
| sd_in | input | 1 | Serial data, MSB first |
| left_word | output | WORD_W | Last completed left-channel word |
| right_word | output | WORD_W | Last completed right-channel word |
| word_valid | output | 1 | One-cycle strobe when an output word is updated |
| word_is_right | output | 1 | Channel tag of the strobe: 1 right, 0 left |

## Verification
On every cycle, the in-line properties check the following:
- the pointer is never more than one-hot;
- the pointer reloads at the MSB after a channel change;
- once the pointer has run off the end it stays idle;
- the capture register clears at each change;
- a strobe never appears without a preceding change;
- the opposite channel register holds during a commit.

Only the bench scenarios can show the delivered values. These cover truncation of long words, zero padding of short ones, a short word after a long one, the first word dropped after each reset, and agreement between the two pointer variants over a long random run.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;
endpackage

// File: rtl/aud_rx_edge.sv
// Samples the serial lines and forms the channel-change pulse.
module aud_rx_edge
   import aud_rx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ws,
   input  logic  sd,
   output logic  sd_q,
   output logic  chg,
   output chan_e ended_ch
);
   logic ws_q;
   logic ws_dly;
   logic primed;

   // On the first edge after reset, the delayed copy is loaded from the line
   // itself, so a line already high does not look like a change.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_q   <= 1'b0;
         ws_q   <= 1'b0;
         ws_dly <= 1'b0;
         primed <= 1'b0;
      end else begin
         sd_q   <= sd;
         ws_q   <= ws;
         ws_dly <= primed ? ws_q : ws;
         primed <= 1'b1;
      end
   end

   assign chg      = ws_q ^ ws_dly;
   assign ended_ch = chan_e'(ws_dly);

   // R3: the delayed level seen after a change is the level sampled before it
   p_ended_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (ws_dly == $past(ws_q)));
endmodule

// File: rtl/aud_rx_ptr.sv
// Bit-position pointer: one-hot walker or counter plus decoder.
module aud_rx_ptr #(
   parameter int WORD_W     = 16,
   parameter bit PTR_ONEHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg,
   output logic [WORD_W-1:0] sel
);
   localparam logic [WORD_W-1:0] MSB_HOT = {1'b1, {(WORD_W-1){1'b0}}};

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("aud_rx_ptr: WORD_W must be at least 2");
      end

      if (PTR_ONEHOT) begin : g_onehot
         logic [WORD_W-1:0] hot;
         // The reload on a change takes priority over the shift.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   hot <= '0;
            else if (chg) hot <= MSB_HOT;
            else          hot <= hot >> 1;
         end
         assign sel = hot;
      end else begin : g_counter
         localparam int CNT_W = $clog2(WORD_W + 1);
         localparam logic [CNT_W-1:0] IDLE = CNT_W'(WORD_W);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= IDLE;
            else if (chg)         cnt <= '0;
            else if (cnt != IDLE) cnt <= cnt + 1'b1;
         end
         for (genvar g = 0; g < WORD_W; g++) begin : g_dec
            assign sel[g] = (cnt == CNT_W'(WORD_W - 1 - g));
         end
      end
   endgenerate

   // R2: never more than one position enabled
   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R2: a change points the next bit at the MSB
   p_sel_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (sel == MSB_HOT));
   // R2: the enable walks one position lower per bit
   p_sel_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && sel != '0) |=> (sel == ($past(sel) >> 1)));
   // R4: after the LSB the pointer stays idle until the next change
   p_sel_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && sel == '0) |=> (sel == '0));
endmodule

// File: rtl/aud_rx_cap.sv
// Capture register and left/right output registers.
module aud_rx_cap
   import aud_rx_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg,
   input  chan_e             ended_ch,
   input  logic              sd_q,
   input  logic [WORD_W-1:0] sel,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word,
   output logic              valid,
   output logic              valid_right
);
   logic [WORD_W-1:0] cap;
   logic [WORD_W-1:0] merged;
   logic              armed;

   // The sample at the pointer joins the word, including the final bit that
   // arrives together with the change.
   assign merged = cap | (sd_q ? sel : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap         <= '0;
         armed       <= 1'b0;
         valid       <= 1'b0;
         valid_right <= 1'b0;
         left_word   <= '0;
         right_word  <= '0;
      end else begin
         valid <= 1'b0;
         if (chg) begin
            cap   <= '0;
            armed <= 1'b1;
            if (armed) begin
               valid       <= 1'b1;
               valid_right <= (ended_ch == CH_RIGHT);
               if (ended_ch == CH_RIGHT) right_word <= merged;
               else                      left_word  <= merged;
            end
         end else begin
            cap <= merged;
         end
      end
   end

   // R8: capture starts empty after every change
   p_cap_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (cap == '0));
   // R6: no strobe without a change the cycle before
   p_valid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !chg |=> !valid);
   // R6: a right commit leaves the left word alone
   p_left_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && ended_ch == CH_RIGHT) |=> $stable(left_word));
   // R6: a left commit leaves the right word alone
   p_right_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg && ended_ch == CH_LEFT) |=> $stable(right_word));
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
   import aud_rx_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter bit PTR_ONEHOT = 1'b1
) (
   input  logic              sck,
   input  logic              rst_n,
   input  logic              ws_in,
   input  logic              sd_in,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word,
   output logic              word_valid,
   output logic              word_is_right
);
   logic              sd_q;
   logic              chg;
   chan_e             ended_ch;
   logic [WORD_W-1:0] sel;

   aud_rx_edge u_edge (
      .clk      (sck),
      .rst_n    (rst_n),
      .ws       (ws_in),
      .sd       (sd_in),
      .sd_q     (sd_q),
      .chg      (chg),
      .ended_ch (ended_ch)
   );

   aud_rx_ptr #(.WORD_W(WORD_W), .PTR_ONEHOT(PTR_ONEHOT)) u_ptr (
      .clk   (sck),
      .rst_n (rst_n),
      .chg   (chg),
      .sel   (sel)
   );

   aud_rx_cap #(.WORD_W(WORD_W)) u_cap (
      .clk         (sck),
      .rst_n       (rst_n),
      .chg         (chg),
      .ended_ch    (ended_ch),
      .sd_q        (sd_q),
      .sel         (sel),
      .left_word   (left_word),
      .right_word  (right_word),
      .valid       (word_valid),
      .valid_right (word_is_right)
   );

   // R1: outputs come out of reset cleared
   p_reset_clear_r1: assert property (@(posedge sck)
      $rose(rst_n) |-> (left_word == '0 && right_word == '0 && !word_valid));
endmodule

// File: tb/aud_rx_deser_bench.sv
module aud_rx_deser_bench;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ws = 1'b0;
   logic sd = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] lw_a, rw_a, lw_b, rw_b;
   logic         v_a, vr_a, v_b, vr_b;

   aud_rx_deser #(.WORD_W(W), .PTR_ONEHOT(1'b1)) u_aud_rx_deser (
      .sck(clk), .rst_n(rst_n), .ws_in(ws), .sd_in(sd),
      .left_word(lw_a), .right_word(rw_a), .word_valid(v_a), .word_is_right(vr_a));

   aud_rx_deser #(.WORD_W(W), .PTR_ONEHOT(1'b0)) u_aud_rx_deser_cnt (
      .sck(clk), .rst_n(rst_n), .ws_in(ws), .sd_in(sd),
      .left_word(lw_b), .right_word(rw_b), .word_valid(v_b), .word_is_right(vr_b));

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] exp_l = '0;
   logic [W-1:0] exp_r = '0;
   int           pc = 0;
   bit           pend_valid, pend_right;
   logic [W-1:0] pend_word;
   bit           cur_ch = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Word the requirements predict for a slot of len bits (R4 truncate, R5 pad)
   function automatic logic [W-1:0] exp_fn(input logic [63:0] tx, input int len);
      logic [63:0] m;
      m = tx & ((64'd1 << len) - 64'd1);
      if (len >= W) return W'(m >> (len - W));
      else          return W'(m << (W - len));
   endfunction

   task automatic check_both(input string tag);
      chk({tag, " R6 valid"}, v_a, pend_valid);
      chk({tag, " R9 valid cnt"}, v_b, pend_valid);
      if (pend_valid) begin
         chk({tag, " R3 tag"}, vr_a, pend_right);
         chk({tag, " R9 tag cnt"}, vr_b, pend_right);
      end
      chk({tag, " R3 left"}, lw_a, exp_l);
      chk({tag, " R3 right"}, rw_a, exp_r);
      chk({tag, " R9 left cnt"}, lw_b, exp_l);
      chk({tag, " R9 right cnt"}, rw_b, exp_r);
   endtask

   task automatic step_checks();
      if (pc > 0) begin
         pc--;
         if (pc == 0) begin
            if (pend_valid) begin
               if (pend_right) exp_r = pend_word;
               else            exp_l = pend_word;
            end
            check_both(pend_valid ? "word" : "R7 dropped");
         end
      end else begin
         chk("R6 idle strobe", v_a, 1'b0);
         chk("R9 idle strobe cnt", v_b, 1'b0);
      end
   endtask

   // WS moves to the next channel together with the last bit of the slot.
   task automatic send_slot(input logic [63:0] tx, input int len, input bit expect_valid);
      for (int j = 0; j < len; j++) begin
         @(negedge clk);
         step_checks();
         sd = tx[len-1-j];
         ws = (j == len - 1) ? ~cur_ch : cur_ch;
      end
      pc         = 2;
      pend_valid = expect_valid;
      pend_right = cur_ch;
      pend_word  = exp_fn(tx, len);
      cur_ch     = ~cur_ch;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_checks();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      ws = 1'b0; sd = 1'b0; rst_n = 1'b0; cur_ch = 1'b0; pc = 0;
      exp_l = '0; exp_r = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset left", lw_a, '0);
      chk("R1 reset right", rw_a, '0);
      chk("R1 reset valid", v_a, 1'b0);
      chk("R1 reset cnt", {lw_b, rw_b, v_b}, '0);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      idle(2);
      // R7: the first word after reset is discarded
      send_slot(64'h0000_0000_0000_ABCD, W, 1'b0);
      // R2/R3: a full-length right word
      send_slot(64'h0000_0000_0000_1234, W, 1'b1);
      // R4: a long left word is truncated to its first W bits
      send_slot(64'h0000_0000_0015_5A5F, W + 5, 1'b1);
      // R5: a short right word is zero padded
      send_slot(64'h0000_0000_0000_0005, 3, 1'b1);
      // R8: a long word followed by a very short one
      send_slot(64'h0000_0000_003F_FFFF, W + 3, 1'b1);
      send_slot(64'h0000_0000_0000_0002, 2, 1'b1);
      // R2: only the MSB set lands in the top bit
      send_slot(64'h0000_0000_0000_8000, W, 1'b1);
      send_slot(64'h0000_0000_0000_0001, W, 1'b1);
      // random slot lengths and data
      for (int k = 0; k < 60; k++) begin
         send_slot({$urandom, $urandom}, 2 + int'($urandom_range(W + 4)), 1'b1);
      end
      idle(4);
      // R7: restart after a second reset drops the first word again
      do_reset();
      idle(2);
      send_slot(64'h0000_0000_0000_7777, W, 1'b0);
      send_slot(64'h0000_0000_0000_C3C3, W, 1'b1);
      send_slot(64'h0000_0000_0000_0E1F, W - 4, 1'b1);
      idle(4);
      summary();
      $finish;
   end
endmodule